// File: doc/BRIEF.md
# Data-Side Address Translation with Cache Tag Check

This block translates the data addresses of a small in-order CPU and decides which way of a two-way set-associative data cache holds the addressed line. Its translation table is filled only by software. Dedicated instructions drive an update port that writes one entry per cycle, and a flush input empties the table. No hardware walks page tables. When the CPU runs in user mode, a request looks the table up. When it runs in kernel mode, translation is off and the physical address equals the virtual address. The CPU leaves reset in kernel mode, and taking an exception returns it to kernel mode.

The table lookup runs in the same cycle as the cache tag reads of both ways. Those reads are indexed only by the untranslated 12-bit page offset, because a page is exactly as large as one cache way. One cycle later, the registered physical frame is compared with the tag each way returns. That compare gives the per-way hit, together with a miss or permission-fault indication and the full physical address. The table is direct-mapped: its low virtual page number bits pick the entry, and the rest of the virtual page number is stored as the entry's tag.

Top module: `dmmu_xlate`

## Requirements
- R1: After reset the block is in kernel mode (`mode_user` = 0), every table entry is invalid, and no response is signalled.
- R2: A request made in kernel mode produces a response with `rsp_paddr` equal to the request address, `rsp_perm` = 3'b111, and neither miss nor fault.
- R3: A user-mode request whose virtual page number matches a valid entry responds exactly one cycle after the request. `rsp_paddr` is the stored 20-bit frame followed by the untranslated low 12 address bits, and `rsp_perm` is the stored permission field. In a cycle with no response, `rsp_valid`, `rsp_miss`, `rsp_fault` and `rsp_way_hit` are all 0.
- R4: A user-mode request raises `rsp_miss` when the selected entry is invalid or its stored tag differs from the request's upper virtual page bits.
- R5: The permission field is {read, write, execute}, with read at bit 2, write at bit 1 and execute at bit 0. A user-mode load needs bit 2 and a store needs bit 1; when the matched entry lacks the needed bit, `rsp_fault` is raised. Miss and fault are never high together.
- R6: `rsp_way_hit[w]` is 1 when four conditions hold in the response cycle: the response is valid, it has neither miss nor fault, `way_tag_vld[w]` is 1, and tag field w of `way_tags` (bits 20*w+19 down to 20*w) equals the physical frame number. Kernel-mode responses compare against the untranslated upper address bits.
- R7: An entry written through the update port can be seen by a lookup in the next cycle. A lookup made in the same cycle as the write sees the old contents.
- R8: `upd_flush` makes every entry invalid from the next cycle on. When a flush and a write happen in the same cycle, the flush wins and the written entry is left invalid.
- R9: `trap_enter` switches to kernel mode and `trap_return` switches to user mode, each taking effect for requests in the following cycle. When both are high, `trap_enter` wins. A request uses the mode in force in its own cycle.
- R10: The entry index is virtual page number bits [3:0]. Writing a page that shares those bits with an earlier page replaces the earlier one, so a lookup of the earlier page then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_enter | input | 1 | Exception taken: go to kernel mode |
| trap_return | input | 1 | Return from exception: go to user mode |
| mode_user | output | 1 | 1 when the CPU is in user mode |
| req_valid | input | 1 | Data access request this cycle |
| req_vaddr | input | 32 | Virtual address of the request |
| req_write | input | 1 | 1 = store, 0 = load |
| upd_en | input | 1 | Write one table entry |
| upd_vpn | input | 20 | Virtual page number of the written entry |
| upd_ppn | input | 20 | Physical frame number of the written entry |
| upd_perm | input | 3 | Permissions {read, write, execute} of the written entry |
| upd_flush | input | 1 | Invalidate all entries |
| way_tags | input | 40 | Physical tags read from the cache ways, way 0 in the low 20 bits |
| way_tag_vld | input | 2 | Line valid bit per way |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_miss | output | 1 | No valid matching entry (user mode) |
| rsp_fault | output | 1 | Matched entry lacks the needed permission |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Permissions of the translation |
| rsp_way_hit | output | 2 | Per-way cache hit |

## Verification
The bench keeps its own table, mode flag and pending response, and predicts every output on every cycle. It aims at the write-then-lookup boundary. A design that forwarded a same-cycle write would hit one cycle early, and one that delayed the write would miss one cycle late. It also covers a flush that collides with a write, where a design that let the write win would leave a live entry behind. Index aliasing between two pages is tested: a design that compared only the index would falsely hit on the evicted page. Loads and stores are each run against every permission mix, which exposes swapped read and write bits and faults reported alongside misses. Way-hit checks vary which way matches, clear the line-valid bits, and present matching tags on a faulting access, so a design that ignored a condition would report a hit the cache does not have. Simultaneous trap entry and return checks that entry takes priority.

// File: rtl/dmmu_pkg.sv
package dmmu_pkg;
   // permission field layout: read at bit 2, write at bit 1, execute at bit 0
   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } perm_t;

   typedef enum logic {
      ACC_LOAD  = 1'b0,
      ACC_STORE = 1'b1
   } acc_t;

   localparam logic [2:0] PERM_ALL = 3'b111;
endpackage

// File: rtl/dmmu_tlb_store.sv
module dmmu_tlb_store #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic [2:0]       wr_perm,
   input  logic             flush,
   input  logic [VPN_W-1:0] rd_vpn,
   output logic             rd_match,
   output logic [PPN_W-1:0] rd_ppn,
   output logic [2:0]       rd_perm
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = VPN_W - IDX_W;

   logic [ENTRIES-1:0] vld_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   logic [2:0]         perm_q [ENTRIES];

   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;

   assign wr_idx = wr_vpn[IDX_W-1:0];
   assign rd_idx = rd_vpn[IDX_W-1:0];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[e]  <= 1'b0;
            tag_q[e]  <= '0;
            ppn_q[e]  <= '0;
            perm_q[e] <= '0;
         end else if (flush) begin
            vld_q[e]  <= 1'b0;
         end else if (sel) begin
            vld_q[e]  <= 1'b1;
            tag_q[e]  <= wr_vpn[VPN_W-1:IDX_W];
            ppn_q[e]  <= wr_ppn;
            perm_q[e] <= wr_perm;
         end
      end
   end

   assign rd_match = vld_q[rd_idx] && (tag_q[rd_idx] == rd_vpn[VPN_W-1:IDX_W]);
   assign rd_ppn   = ppn_q[rd_idx];
   assign rd_perm  = perm_q[rd_idx];
endmodule

// File: rtl/dmmu_perm_gate.sv
module dmmu_perm_gate
   import dmmu_pkg::*;
(
   input  logic       valid,
   input  logic       user,
   input  logic       match,
   input  logic       write,
   input  logic [2:0] perm,
   output logic       miss,
   output logic       fault
);
   perm_t p;
   logic  allowed;

   assign p = perm_t'(perm);

   always_comb begin
      unique case (acc_t'(write))
         ACC_STORE: allowed = p.wr;
         default:   allowed = p.rd;
      endcase
   end

   assign miss  = valid && user && !match;
   assign fault = valid && user && match && !allowed;
endmodule

// File: rtl/dmmu_way_cmp.sv
module dmmu_way_cmp #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 20
) (
   input  logic                  enable,
   input  logic [TAG_W-1:0]      frame,
   input  logic [WAYS*TAG_W-1:0] tags,
   input  logic [WAYS-1:0]       tag_vld,
   output logic [WAYS-1:0]       hit
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hit[w] = enable && tag_vld[w] && (tags[w*TAG_W +: TAG_W] == frame);
   end
endmodule

// File: rtl/dmmu_xlate.sv
module dmmu_xlate
   import dmmu_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int PAGE_W  = 12,
   parameter int ENTRIES = 16,
   parameter int WAYS    = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           trap_enter,
   input  logic                           trap_return,
   output logic                           mode_user,
   input  logic                           req_valid,
   input  logic [VA_W-1:0]                req_vaddr,
   input  logic                           req_write,
   input  logic                           upd_en,
   input  logic [VA_W-PAGE_W-1:0]         upd_vpn,
   input  logic [PA_W-PAGE_W-1:0]         upd_ppn,
   input  logic [2:0]                     upd_perm,
   input  logic                           upd_flush,
   input  logic [WAYS*(PA_W-PAGE_W)-1:0]  way_tags,
   input  logic [WAYS-1:0]                way_tag_vld,
   output logic                           rsp_valid,
   output logic                           rsp_miss,
   output logic                           rsp_fault,
   output logic [PA_W-1:0]                rsp_paddr,
   output logic [2:0]                     rsp_perm,
   output logic [WAYS-1:0]                rsp_way_hit
);
   localparam int VPN_W = VA_W - PAGE_W;
   localparam int PPN_W = PA_W - PAGE_W;

   if (VA_W != PA_W) begin : g_chk_width
      $error("dmmu_xlate: kernel bypass needs equal virtual and physical widths");
   end
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_chk_entries
      $error("dmmu_xlate: ENTRIES must be a power of two, at least 2");
   end
   if ($clog2(ENTRIES) >= VPN_W) begin : g_chk_index
      $error("dmmu_xlate: index wider than the virtual page number");
   end
   if (WAYS < 1) begin : g_chk_ways
      $error("dmmu_xlate: WAYS must be at least 1");
   end

   // privilege state: kernel out of reset, exception entry dominates
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mode_user <= 1'b0;
      else if (trap_enter)  mode_user <= 1'b0;
      else if (trap_return) mode_user <= 1'b1;
   end

   // stage 0: table lookup alongside the cache tag reads
   logic             tbl_match;
   logic [PPN_W-1:0] tbl_ppn;
   logic [2:0]       tbl_perm;

   dmmu_tlb_store #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (upd_en),
      .wr_vpn   (upd_vpn),
      .wr_ppn   (upd_ppn),
      .wr_perm  (upd_perm),
      .flush    (upd_flush),
      .rd_vpn   (req_vaddr[VA_W-1:PAGE_W]),
      .rd_match (tbl_match),
      .rd_ppn   (tbl_ppn),
      .rd_perm  (tbl_perm)
   );

   logic             s0_match;
   logic [PPN_W-1:0] s0_ppn;
   logic [2:0]       s0_perm;

   always_comb begin
      if (mode_user) begin
         s0_match = tbl_match;
         s0_ppn   = tbl_ppn;
         s0_perm  = tbl_perm;
      end else begin
         s0_match = 1'b1;
         s0_ppn   = PPN_W'(req_vaddr[VA_W-1:PAGE_W]);
         s0_perm  = PERM_ALL;
      end
   end

   // stage 1 registers
   logic              s1_valid;
   logic              s1_user;
   logic              s1_write;
   logic              s1_match;
   logic [PPN_W-1:0]  s1_ppn;
   logic [2:0]        s1_perm;
   logic [PAGE_W-1:0] s1_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_user  <= 1'b0;
         s1_write <= 1'b0;
         s1_match <= 1'b0;
         s1_ppn   <= '0;
         s1_perm  <= '0;
         s1_off   <= '0;
      end else begin
         s1_valid <= req_valid;
         if (req_valid) begin
            s1_user  <= mode_user;
            s1_write <= req_write;
            s1_match <= s0_match;
            s1_ppn   <= s0_ppn;
            s1_perm  <= s0_perm;
            s1_off   <= req_vaddr[PAGE_W-1:0];
         end
      end
   end

   // stage 1: permission gate and physical tag compare
   logic hit_ok;

   dmmu_perm_gate u_gate (
      .valid (s1_valid),
      .user  (s1_user),
      .match (s1_match),
      .write (s1_write),
      .perm  (s1_perm),
      .miss  (rsp_miss),
      .fault (rsp_fault)
   );

   assign hit_ok = s1_valid && !rsp_miss && !rsp_fault;

   dmmu_way_cmp #(
      .WAYS  (WAYS),
      .TAG_W (PPN_W)
   ) u_cmp (
      .enable  (hit_ok),
      .frame   (s1_ppn),
      .tags    (way_tags),
      .tag_vld (way_tag_vld),
      .hit     (rsp_way_hit)
   );

   assign rsp_valid = s1_valid;
   assign rsp_paddr = {s1_ppn, s1_off};
   assign rsp_perm  = s1_perm;
endmodule

// File: rtl/dmmu_xlate_chk.sv
module dmmu_xlate_chk #(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int PAGE_W = 12,
   parameter int WAYS   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trap_enter,
   input logic              mode_user,
   input logic [VA_W-1:0]   req_vaddr,
   input logic              rsp_valid,
   input logic              rsp_miss,
   input logic              rsp_fault,
   input logic [PA_W-1:0]   rsp_paddr,
   input logic [2:0]        rsp_perm,
   input logic [WAYS-1:0]   rsp_way_hit
);
   // R5: miss and fault exclusive
   assert_miss_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_miss && rsp_fault));

   // R3: no flags without a response
   assert_quiet_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_miss && !rsp_fault && rsp_way_hit == '0));

   // R3: page offset passes through untranslated
   assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_paddr[PAGE_W-1:0] == $past(req_vaddr[PAGE_W-1:0]));

   // R2: kernel-mode requests bypass translation
   assert_kernel_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(mode_user)) |->
         (rsp_paddr == PA_W'($past(req_vaddr)) && !rsp_miss && !rsp_fault && rsp_perm == 3'b111));

   // R6: a way hit only on a clean translation
   assert_hit_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_way_hit != '0) |-> (rsp_valid && !rsp_miss && !rsp_fault));

   // R9: exception entry lands in kernel mode
   assert_trap_kernel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_enter |=> !mode_user);
endmodule

bind dmmu_xlate dmmu_xlate_chk #(
   .VA_W   (VA_W),
   .PA_W   (PA_W),
   .PAGE_W (PAGE_W),
   .WAYS   (WAYS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .trap_enter  (trap_enter),
   .mode_user   (mode_user),
   .req_vaddr   (req_vaddr),
   .rsp_valid   (rsp_valid),
   .rsp_miss    (rsp_miss),
   .rsp_fault   (rsp_fault),
   .rsp_paddr   (rsp_paddr),
   .rsp_perm    (rsp_perm),
   .rsp_way_hit (rsp_way_hit)
);

// File: tb/dmmu_xlate_bench.sv
module dmmu_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_enter = 1'b0, trap_return = 1'b0;
   logic        mode_user;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        upd_en = 1'b0;
   logic [19:0] upd_vpn = '0, upd_ppn = '0;
   logic [2:0]  upd_perm = '0;
   logic        upd_flush = 1'b0;
   logic [39:0] way_tags = '0;
   logic [1:0]  way_tag_vld = '0;
   logic        rsp_valid, rsp_miss, rsp_fault;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_perm;
   logic [1:0]  rsp_way_hit;

   always #10 clk = ~clk;

   dmmu_xlate u_dmmu_xlate (
      .clk, .rst_n, .trap_enter, .trap_return, .mode_user,
      .req_valid, .req_vaddr, .req_write,
      .upd_en, .upd_vpn, .upd_ppn, .upd_perm, .upd_flush,
      .way_tags, .way_tag_vld,
      .rsp_valid, .rsp_miss, .rsp_fault, .rsp_paddr, .rsp_perm, .rsp_way_hit
   );

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string scen = "R1";

   // reference model state
   bit          m_user = 1'b0;
   bit          m_vld  [16];
   logic [19:0] m_vpn  [16];
   logic [19:0] m_ppn  [16];
   logic [2:0]  m_perm [16];

   // pending response expectation
   bit          p_valid = 1'b0, p_miss, p_fault;
   logic [31:0] p_paddr;
   logic [2:0]  p_perm;
   logic [1:0]  p_hit;
   logic [39:0] p_tags = '0;
   logic [1:0]  p_tv = '0;

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", scen, what, act, exp);
      end
   endtask

   task automatic step(input bit rv, input logic [31:0] va, input bit wr,
                       input bit ue, input logic [19:0] uvpn, input logic [19:0] uppn,
                       input logic [2:0] uperm, input bit fl, input bit te, input bit tr,
                       input logic [19:0] t0, input logic [19:0] t1, input logic [1:0] tv);
      int idx;
      bit hitm;
      logic [19:0] fr;
      way_tags = p_tags; way_tag_vld = p_tv;
      req_valid = rv; req_vaddr = va; req_write = wr;
      upd_en = ue; upd_vpn = uvpn; upd_ppn = uppn; upd_perm = uperm; upd_flush = fl;
      trap_enter = te; trap_return = tr;
      #1;
      check(mode_user == m_user, "mode", 32'(mode_user), 32'(m_user));
      check(rsp_valid == p_valid, "valid", 32'(rsp_valid), 32'(p_valid));
      if (p_valid) begin
         check(rsp_miss == p_miss, "miss", 32'(rsp_miss), 32'(p_miss));
         check(rsp_fault == p_fault, "fault", 32'(rsp_fault), 32'(p_fault));
         if (!p_miss) begin
            check(rsp_paddr == p_paddr, "paddr", rsp_paddr, p_paddr);
            check(rsp_perm == p_perm, "perm", 32'(rsp_perm), 32'(p_perm));
         end
         check(rsp_way_hit == p_hit, "way_hit", 32'(rsp_way_hit), 32'(p_hit));
      end else begin
         check(!rsp_miss && !rsp_fault && rsp_way_hit == 2'b00, "idle flags",
               {29'd0, rsp_miss, rsp_fault, |rsp_way_hit}, 32'd0);
      end
      // expectation for this cycle's request
      p_valid = rv; p_tags = {t1, t0}; p_tv = tv;
      p_miss = 1'b0; p_fault = 1'b0; p_hit = 2'b00;
      if (!m_user) begin
         p_paddr = va; p_perm = 3'b111; fr = va[31:12];
      end else begin
         idx = int'(va[15:12]);
         hitm = m_vld[idx] && (m_vpn[idx] == va[31:12]);
         p_miss = !hitm;
         fr = m_ppn[idx];
         p_perm = m_perm[idx];
         p_paddr = {m_ppn[idx], va[11:0]};
         if (hitm) p_fault = wr ? !m_perm[idx][1] : !m_perm[idx][2];
      end
      if (rv && !p_miss && !p_fault) begin
         p_hit[0] = tv[0] && (t0 == fr);
         p_hit[1] = tv[1] && (t1 == fr);
      end
      // model updates at the edge
      if (fl) begin
         for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
      end else if (ue) begin
         m_vld[uvpn[3:0]] = 1'b1; m_vpn[uvpn[3:0]] = uvpn;
         m_ppn[uvpn[3:0]] = uppn; m_perm[uvpn[3:0]] = uperm;
      end
      if (te) m_user = 1'b0;
      else if (tr) m_user = 1'b1;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00);
   endtask
   task automatic rq(input logic [31:0] va, input bit wr, input logic [19:0] t0,
                     input logic [19:0] t1, input logic [1:0] tv);
      step(1, va, wr, 0, 0, 0, 0, 0, 0, 0, t0, t1, tv);
   endtask
   task automatic put(input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] pm);
      step(0, 0, 0, 1, vpn, ppn, pm, 0, 0, 0, 0, 0, 2'b00);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_vld[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      scen = "R1";
      check(mode_user == 1'b0, "reset mode", 32'(mode_user), 32'd0);
      check(rsp_valid == 1'b0, "reset valid", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: table starts empty (checked in user mode below), kernel mode first
      scen = "R2";
      rq(32'h1234_5678, 0, 20'h12345, 20'h00000, 2'b01);
      rq(32'hFFFF_F000, 1, 20'h00001, 20'hFFFFF, 2'b10);
      for (int k = 0; k < 8; k++) begin
         logic [31:0] a;
         a = $urandom;
         rq(a, k[0], a[31:12], a[31:12] ^ 20'h1, 2'b11);
      end
      idle();
      scen = "R9";
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 2'b00);
      idle();
      scen = "R1";
      rq(32'h1234_5ABC, 0, 0, 0, 2'b00);
      rq(32'h0000_0000, 1, 0, 0, 2'b00);
      scen = "R7";
      step(1, 32'h1234_5ABC, 0, 1, 20'h12345, 20'hABCDE, 3'b111, 0, 0, 0, 20'hABCDE, 0, 2'b01);
      rq(32'h1234_5ABC, 0, 20'hABCDE, 0, 2'b01);
      scen = "R3";
      put(20'h00013, 20'h11111, 3'b100);
      put(20'h7777A, 20'h22222, 3'b010);
      put(20'hFFFFF, 20'h33333, 3'b001);
      rq(32'h0001_3004, 0, 20'h11111, 20'h11110, 2'b11);
      rq(32'h7777_AFFF, 1, 20'h00000, 20'h22222, 2'b10);
      rq(32'h1234_5001, 1, 20'hABCDE, 20'hABCDE, 2'b11);
      scen = "R4";
      rq(32'h1234_6000, 0, 0, 0, 2'b00);
      rq(32'h0011_3000, 0, 20'h11111, 0, 2'b01);
      scen = "R5";
      rq(32'h0001_3010, 1, 20'h11111, 20'h11111, 2'b11);
      rq(32'h7777_A020, 0, 20'h22222, 0, 2'b01);
      rq(32'hFFFF_F030, 0, 20'h33333, 0, 2'b01);
      rq(32'hFFFF_F040, 1, 20'h33333, 20'h33333, 2'b11);
      scen = "R6";
      rq(32'h1234_5100, 0, 20'hABCDE, 20'hABCDE, 2'b00);
      rq(32'h1234_5200, 0, 20'hABCDE, 20'hABCDE, 2'b10);
      rq(32'h1234_5300, 1, 20'hABCDF, 20'hABCDE, 2'b11);
      rq(32'h1234_5400, 0, 20'hABCDE, 20'h0BCDE, 2'b11);
      scen = "R10";
      put(20'h54325, 20'h44444, 3'b110);
      rq(32'h1234_5000, 0, 20'hABCDE, 0, 2'b01);
      rq(32'h5432_5008, 1, 20'h44444, 0, 2'b01);
      scen = "R8";
      step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 2'b00);
      rq(32'h0001_3000, 0, 20'h11111, 0, 2'b01);
      put(20'h00013, 20'h11111, 3'b100);
      step(1, 32'h0001_3000, 0, 1, 20'h7777A, 20'h22222, 3'b010, 1, 0, 0, 20'h11111, 0, 2'b01);
      rq(32'h7777_A000, 1, 20'h22222, 0, 2'b01);
      rq(32'h0001_3000, 0, 20'h11111, 0, 2'b01);
      scen = "R9";
      step(1, 32'h0001_3000, 0, 0, 0, 0, 0, 0, 1, 1, 20'h00013, 0, 2'b01);
      rq(32'h0001_3000, 0, 20'h00013, 0, 2'b01);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 2'b00);
      step(1, 32'h7777_A000, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 2'b00);
      idle();
      idle();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog run hung actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule